// File: doc/BRIEF.md
# Four-Bit Arithmetic and Logic Unit with Sign Flags

This block is a purely combinational arithmetic and logic unit. It takes two unsigned operands, four bits wide by default, and a three-bit function code. It returns a result one bit wider than the operands, together with carry, negative and overflow flags. Before any operation, each operand is widened by one bit with a zero in the top position. The result is the operation applied to these widened values.

Six function codes are defined: add, subtract, double the first operand, and bitwise AND, OR and XOR. When a subtraction would go below zero, the result is the wrapped two's complement difference and both the negative and overflow flags are raised. The two unused function codes force the result to all ones and clear every flag. Operand registers, sequencing and display conversion belong to the logic around this block. The block has no clock and no state: the outputs follow the inputs directly.

Top module: `sflag_alu`

## Requirements
- R1: Function code 3'b000 (add) gives result = {0,A} + {0,B}. Negative and overflow are 0.
- R2: Function code 3'b001 (subtract) with B not greater than A gives result = A - B. Carry, negative and overflow are all 0.
- R3: Function code 3'b001 with B greater than A gives result = ({0,A} - {0,B}) mod 32, which is the 5-bit two's complement difference. Negative and overflow are both 1 and carry is 0.
- R4: Function code 3'b010 (double) gives result = {0,A} + {0,A}. B is ignored. Negative and overflow are 0.
- R5: Function codes 3'b011 (AND), 3'b100 (OR) and 3'b101 (XOR) give the bitwise operation of the zero-extended operands, so result bit 4 is 0. All three flags are 0.
- R6: Function codes 3'b110 and 3'b111 give result = 5'b11111 with all three flags 0, whatever the operands are.
- R7: For add and double, carry equals result bit 4. For every other function code, carry is 0.
- R8: The block is combinational. A change on any input shows at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 4 | First operand (A), unsigned |
| opb_i | input | 4 | Second operand (B), unsigned |
| func_i | input | 3 | Function code (see R1 to R6) |
| result_o | output | 5 | Result, one bit wider than the operands |
| carry_o | output | 1 | Carry out for add and double |
| neg_o | output | 1 | Negative result of a subtraction |
| ovf_o | output | 1 | Overflow of a subtraction (B greater than A) |

## Verification
The block holds no state, so any fault in the function decoder or the borrow compare shows at the ports in the same delta cycle as the input change that exposes it. The bench changes the inputs, waits a small settle time inside one clock period, and compares against a model. The most fragile points are the borrow boundary (B equal to A versus B equal to A plus one), the carry out of the largest sums, and the two unused codes. Directed vectors target each of these points. Seeded random vectors cover the rest of the input space.

// File: rtl/sflag_alu_pkg.sv
package sflag_alu_pkg;
    parameter int unsigned OP_W   = 4;
    parameter int unsigned FUNC_W = 3;
    localparam int unsigned RES_W = OP_W + 1;

    typedef enum logic [FUNC_W-1:0] {
        FN_ADD = 3'b000,
        FN_SUB = 3'b001,
        FN_DBL = 3'b010,
        FN_AND = 3'b011,
        FN_OR  = 3'b100,
        FN_XOR = 3'b101
    } alu_fn_e;

    typedef struct packed {
        logic [RES_W-1:0] value;
        logic             carry;
        logic             neg;
        logic             ovf;
    } alu_out_t;
endpackage

// File: rtl/sflag_arith.sv
module sflag_arith
    import sflag_alu_pkg::*;
#(
    parameter int unsigned W = OP_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W:0]   sum_o,
    output logic [W:0]   diff_o,
    output logic [W:0]   dbl_o,
    output logic         borrow_o
);
    logic [W:0] a_ext;
    logic [W:0] b_ext;

    always_comb begin
        a_ext    = {1'b0, a_i};
        b_ext    = {1'b0, b_i};
        sum_o    = a_ext + b_ext;
        diff_o   = a_ext - b_ext;
        dbl_o    = a_ext + a_ext;
        borrow_o = (b_i > a_i);
    end
endmodule

// File: rtl/sflag_bitops.sv
module sflag_bitops
    import sflag_alu_pkg::*;
#(
    parameter int unsigned W = OP_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W:0]   and_o,
    output logic [W:0]   or_o,
    output logic [W:0]   xor_o
);
    // The top bit comes from the zero extension, so it is always 0.
    assign and_o[W] = 1'b0;
    assign or_o[W]  = 1'b0;
    assign xor_o[W] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign and_o[i] = a_i[i] & b_i[i];
        assign or_o[i]  = a_i[i] | b_i[i];
        assign xor_o[i] = a_i[i] ^ b_i[i];
    end
endmodule

// File: rtl/sflag_alu.sv
module sflag_alu
    import sflag_alu_pkg::*;
(
    input  logic [OP_W-1:0]   opa_i,
    input  logic [OP_W-1:0]   opb_i,
    input  logic [FUNC_W-1:0] func_i,
    output logic [RES_W-1:0]  result_o,
    output logic              carry_o,
    output logic              neg_o,
    output logic              ovf_o
);
    logic [RES_W-1:0] sum_w, diff_w, dbl_w, and_w, or_w, xor_w;
    logic             borrow_w;
    alu_out_t         sel;

    sflag_arith #(.W(OP_W)) arith_i (
        .a_i      (opa_i),
        .b_i      (opb_i),
        .sum_o    (sum_w),
        .diff_o   (diff_w),
        .dbl_o    (dbl_w),
        .borrow_o (borrow_w)
    );

    sflag_bitops #(.W(OP_W)) bitops_i (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .and_o (and_w),
        .or_o  (or_w),
        .xor_o (xor_w)
    );

    always_comb begin
        sel = '{value: '1, carry: 1'b0, neg: 1'b0, ovf: 1'b0};
        unique case (alu_fn_e'(func_i))
            FN_ADD: begin
                sel.value = sum_w;
                sel.carry = sum_w[RES_W-1];
            end
            FN_SUB: begin
                sel.value = diff_w;
                sel.neg   = borrow_w;
                sel.ovf   = borrow_w;
            end
            FN_DBL: begin
                sel.value = dbl_w;
                sel.carry = dbl_w[RES_W-1];
            end
            FN_AND:  sel.value = and_w;
            FN_OR:   sel.value = or_w;
            FN_XOR:  sel.value = xor_w;
            default: sel.value = '1;
        endcase
    end

    assign result_o = sel.value;
    assign carry_o  = sel.carry;
    assign neg_o    = sel.neg;
    assign ovf_o    = sel.ovf;
endmodule

// File: rtl/sflag_alu_chk.sv
module sflag_alu_chk
    import sflag_alu_pkg::*;
(
    input logic [OP_W-1:0]   opa_i,
    input logic [OP_W-1:0]   opb_i,
    input logic [FUNC_W-1:0] func_i,
    input logic [RES_W-1:0]  result_o,
    input logic              carry_o,
    input logic              neg_o,
    input logic              ovf_o
);
    always_comb begin
        if (!$isunknown({opa_i, opb_i, func_i})) begin
            if (func_i == 3'b000) begin
                a_r1_add_value: assert (32'(result_o) == 32'(opa_i) + 32'(opb_i))
                    else $error("add value");
            end
            if (func_i == 3'b001 && opb_i <= opa_i) begin
                a_r2_no_borrow: assert (!neg_o && !ovf_o && !carry_o
                                        && 32'(result_o) == 32'(opa_i) - 32'(opb_i))
                    else $error("subtract without borrow");
            end
            if (func_i == 3'b001 && opb_i > opa_i) begin
                a_r3_borrow_flags: assert (neg_o && ovf_o && !carry_o && result_o[RES_W-1])
                    else $error("subtract with borrow");
            end
            if (func_i == 3'b010) begin
                a_r4_double: assert (32'(result_o) == 2 * 32'(opa_i) && !neg_o && !ovf_o)
                    else $error("double");
            end
            if (func_i >= 3'b011 && func_i <= 3'b101) begin
                a_r5_logic_clear: assert (!result_o[RES_W-1] && !carry_o && !neg_o && !ovf_o)
                    else $error("logic flags");
            end
            if (func_i > 3'b101) begin
                a_r6_invalid_ones: assert (&result_o && !carry_o && !neg_o && !ovf_o)
                    else $error("invalid code");
            end
            if (func_i == 3'b000 || func_i == 3'b010) begin
                a_r7_carry_top: assert (carry_o == result_o[RES_W-1])
                    else $error("carry mismatch");
            end else begin
                a_r7_carry_low: assert (!carry_o)
                    else $error("stray carry");
            end
        end
    end
endmodule

bind sflag_alu sflag_alu_chk chk_i (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .func_i   (func_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .neg_o    (neg_o),
    .ovf_o    (ovf_o)
);

// File: tb/sflag_alu_tb_top.sv
module sflag_alu_tb_top;
    logic       clk = 1'b0;
    logic [3:0] opa, opb;
    logic [2:0] func;
    logic [4:0] result;
    logic       carry, neg, ovf;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk;

    sflag_alu dut_i (
        .opa_i    (opa),
        .opb_i    (opb),
        .func_i   (func),
        .result_o (result),
        .carry_o  (carry),
        .neg_o    (neg),
        .ovf_o    (ovf)
    );

    // Model: returns {result, carry, neg, ovf}
    function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b,
                                         input logic [2:0] f);
        int r;
        logic c, n, o;
        c = 0; n = 0; o = 0;
        case (f)
            3'd0: begin r = a + b; c = (r > 15); end
            3'd1: begin r = (int'(a) - int'(b)) & 31; n = (b > a); o = (b > a); end
            3'd2: begin r = 2 * a; c = (r > 15); end
            3'd3: r = a & b;
            3'd4: r = a | b;
            3'd5: r = a ^ b;
            default: r = 31;
        endcase
        return {r[4:0], c, n, o};
    endfunction

    function automatic string req_of(input logic [2:0] f, input logic [3:0] a,
                                     input logic [3:0] b);
        case (f)
            3'd0: return "R1/R7";
            3'd1: return (b > a) ? "R3" : "R2";
            3'd2: return "R4/R7";
            3'd3, 3'd4, 3'd5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [2:0] f);
        logic [7:0] exp;
        @(negedge clk);
        opa = a; opb = b; func = f;
        #1;
        exp = model(a, b, f);
        n_vec++;
        if ({result, carry, neg, ovf} !== exp) begin
            n_bad++;
            $display("FAIL %s a=%0d b=%0d f=%0d actual=%b/%b%b%b expected=%b/%b%b%b",
                     req_of(f, a, b), a, b, f, result, carry, neg, ovf,
                     exp[7:3], exp[2], exp[1], exp[0]);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20151112));
        opa = 0; opb = 0; func = 0;
        // First vector plays the role of the idle state check: all zero inputs
        apply(4'd0, 4'd0, 3'd0);        // R1 zero
        apply(4'd15, 4'd15, 3'd0);      // R1/R7 max carry: 30
        apply(4'd8, 4'd8, 3'd0);        // R7 carry boundary: 16
        apply(4'd7, 4'd8, 3'd0);        // R7 no carry: 15
        apply(4'd5, 4'd5, 3'd1);        // R2 equal operands
        apply(4'd15, 4'd0, 3'd1);       // R2
        apply(4'd5, 4'd6, 3'd1);        // R3 borrow boundary -> 31
        apply(4'd0, 4'd15, 3'd1);       // R3 -> 17
        apply(4'd8, 4'd3, 3'd2);        // R4 double with carry
        apply(4'd8, 4'd12, 3'd2);       // R4 B ignored
        apply(4'd7, 4'd0, 3'd2);        // R4 no carry
        apply(4'd15, 4'd15, 3'd3);      // R5 AND
        apply(4'd10, 4'd5, 3'd4);       // R5 OR
        apply(4'd15, 4'd15, 3'd5);      // R5 XOR -> 0
        apply(4'd0, 4'd0, 3'd6);        // R6
        apply(4'd15, 4'd15, 3'd7);      // R6
        // R8: input change seen within one half period, no edge in between
        @(negedge clk);
        opa = 4'd3; opb = 4'd9; func = 3'd1;
        #0.5;
        n_vec++;
        if (result !== 5'd26 || !neg || !ovf) begin
            n_bad++;
            $display("FAIL R8 actual=%0d/%b%b expected=26/11", result, neg, ovf);
        end
        for (int i = 0; i < 3000; i++) begin
            apply(4'($urandom), 4'($urandom), 3'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule